// File: doc/BRIEF.md
# Floating-Point Condition Predicate Unit

This unit keeps the three condition bits left by the most recent floating-point compare or arithmetic result: negative, zero and not-a-number. On request it evaluates one of 32 conditional predicates against them. The answer feeds a branch, a set-on-condition or a conditional trap. The not-a-number bit stands for the unordered outcome. Because of it the predicates do not follow integer trichotomy: greater-than and less-or-equal are both false when the operands are unordered, and the complement of each test is its "not" form.

Bit 4 of the predicate code splits the predicates into two groups. The quiet group states ordered or unordered explicitly in each test and never reports anything. The signaling group raises a sticky unordered-condition flag whenever it is evaluated on an unordered result, except for the equal and not-equal tests. When the trap-enable input is high, such an event also produces a one-cycle trap request.

A two-state report machine carries the registered result. After reset it is in ST_IDLE. It moves to ST_REPORT on any edge where the evaluate strobe is high, and it returns to ST_IDLE on any edge where the strobe is low. It stays in ST_REPORT through a run of back-to-back evaluations.

Top module: `fpp_cond_unit`

## Requirements
- R1: The condition bits are captured only on a clock edge with `cc_wr` high and are held otherwise. An evaluation in the same cycle as a capture uses the bits held before that capture.
- R2: The result depends only on the ordering class, taken in this order: unordered if nan=1, else equal if zero=1, else less if neg=1, else greater. For codes[3:0] 0..15 the tests are true on these classes: 0 never; 1 equal; 2 greater; 3 greater or equal; 4 less; 5 less or equal; 6 less or greater; 7 any ordered; 8 unordered; 9 unordered or equal; 10 unordered or greater; 11 unordered, greater or equal; 12 unordered or less; 13 unordered, less or equal; 14 all but equal; 15 always. Code bit 4 does not change the result.
- R3: For every class, relations k and 15−k give opposite results. In particular, unordered makes greater (2) and less-or-equal (5) both false.
- R4: An evaluation with code bit 4 = 1 and nan=1 sets the sticky `unord_flag`, unless codes[3:0] is 1 or 14.
- R5: An evaluation with code bit 4 = 0 never sets `unord_flag`.
- R6: `res_vld` and `res_bit` appear one cycle after the edge that samples `eval_go`. When `res_vld` is low, `res_bit` is 0.
- R7: `trap_req` is high for the single result cycle of an evaluation that sets the flag condition of R4 while `trap_en` was high at that evaluation.
- R8: `unord_flag` stays set until an edge with `flag_clr` high. If a set event falls on the same edge as the clear, the flag stays set.
- R9: During and right after reset, `res_vld`, `res_bit`, `unord_flag` and `trap_req` are 0, and the held condition bits are 0, so the class is greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_wr | input | 1 | Capture strobe for the condition bits |
| cc_neg | input | 1 | Negative bit of the new result |
| cc_zero | input | 1 | Zero bit of the new result |
| cc_nan | input | 1 | Not-a-number / unordered bit of the new result |
| eval_go | input | 1 | Evaluate strobe |
| eval_code | input | 5 | Predicate code; bit 4 selects the signaling group |
| trap_en | input | 1 | Enables the trap request on a flag event |
| flag_clr | input | 1 | Clears the sticky unordered flag |
| res_vld | output | 1 | Result valid, high in ST_REPORT |
| res_bit | output | 1 | Predicate result |
| unord_flag | output | 1 | Sticky unordered-condition flag |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench builds the unit with its default 4-bit relation field. This yields the full 5-bit code space, so all 32 codes can be swept against all four ordering classes with the trap enable toggling. That sweep reaches every flag-raising and exempt combination, including the equal and not-equal exemptions under a not-a-number result. Directed sequences cover a capture that coincides with an evaluation, a clear that coincides with a set, and back-to-back evaluations that keep the report machine in ST_REPORT.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
    localparam int REL_W  = 4;
    localparam int CODE_W = REL_W + 1;
    localparam int HALF_W = REL_W - 1;
    localparam logic [REL_W-1:0] REL_EQUAL    = REL_W'(1);
    localparam logic [REL_W-1:0] REL_NOTEQUAL = REL_W'((1 << REL_W) - 2);

    typedef struct packed {
        logic neg;
        logic zero;
        logic nan;
    } ccbits_t;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } rpt_state_t;
endpackage

// File: rtl/fpp_cc_hold.sv
module fpp_cc_hold
    import fpp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  ccbits_t d,
    output ccbits_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= d;
        end
    end

    // R1
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
endmodule

// File: rtl/fpp_rel_eval.sv
module fpp_rel_eval
    import fpp_pkg::*;
(
    input  ccbits_t           cc,
    input  logic [CODE_W-1:0] code,
    output logic              truth,
    output logic              unord_hit
);
    logic              is_eq, is_gt, is_lt, is_un;
    logic [REL_W-1:0]  rel;
    logic [HALF_W-1:0] half_sel;
    logic              half_val;

    assign is_un = cc.nan;
    assign is_eq = cc.zero & ~cc.nan;
    assign is_gt = ~cc.neg & ~cc.zero & ~cc.nan;
    assign is_lt = cc.neg & ~cc.zero & ~cc.nan;
    assign rel   = code[REL_W-1:0];

    // upper half of the relation space is the complement of the mirrored lower half
    assign half_sel = rel[REL_W-1] ? ~rel[HALF_W-1:0] : rel[HALF_W-1:0];

    always_comb begin
        unique case (half_sel)
            3'd0: half_val = 1'b0;
            3'd1: half_val = is_eq;
            3'd2: half_val = is_gt;
            3'd3: half_val = is_gt | is_eq;
            3'd4: half_val = is_lt;
            3'd5: half_val = is_lt | is_eq;
            3'd6: half_val = is_gt | is_lt;
            default: half_val = ~is_un;
        endcase
    end

    assign truth     = rel[REL_W-1] ? ~half_val : half_val;
    assign unord_hit = code[CODE_W-1] & is_un
                     & (rel != REL_EQUAL) & (rel != REL_NOTEQUAL);
endmodule

// File: rtl/fpp_report_fsm.sv
module fpp_report_fsm
    import fpp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic truth,
    input  logic hit,
    input  logic trap_en,
    input  logic clr,
    output logic vld,
    output logic res,
    output logic flag,
    output logic trap
);
    rpt_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = go ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = go ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res  <= 1'b0;
            trap <= 1'b0;
            flag <= 1'b0;
        end else begin
            res  <= go & truth;
            trap <= go & hit & trap_en;
            if (go && hit) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    assign vld = (state_q == ST_REPORT);

    // R6
    res_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(go));
    // R6
    res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> !res);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
    // R7
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (flag && vld));
endmodule

// File: rtl/fpp_cond_unit.sv
module fpp_cond_unit
    import fpp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cc_wr,
    input  logic       cc_neg,
    input  logic       cc_zero,
    input  logic       cc_nan,
    input  logic       eval_go,
    input  logic [4:0] eval_code,
    input  logic       trap_en,
    input  logic       flag_clr,
    output logic       res_vld,
    output logic       res_bit,
    output logic       unord_flag,
    output logic       trap_req
);
    ccbits_t cc_new, cc_held;
    logic    truth, hit;

    assign cc_new = '{neg: cc_neg, zero: cc_zero, nan: cc_nan};

    fpp_cc_hold i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cc_wr),
        .d     (cc_new),
        .q     (cc_held)
    );

    fpp_rel_eval i_eval (
        .cc        (cc_held),
        .code      (eval_code),
        .truth     (truth),
        .unord_hit (hit)
    );

    fpp_report_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eval_go),
        .truth   (truth),
        .hit     (hit),
        .trap_en (trap_en),
        .clr     (flag_clr),
        .vld     (res_vld),
        .res     (res_bit),
        .flag    (unord_flag),
        .trap    (trap_req)
    );

    // R5
    quiet_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_go && !eval_code[4] && !unord_flag && !flag_clr |=> !unord_flag);
    // R4
    signal_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_go && eval_code[4] && cc_held.nan
        && eval_code[3:0] != 4'd1 && eval_code[3:0] != 4'd14 |=> unord_flag);
    // R3
    unordered_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_go && cc_held.nan && eval_code[3:0] == 4'd2 |=> !res_bit);
endmodule

// File: tb/test_fpp_cond_unit.sv
module test_fpp_cond_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cc_wr = 1'b0, cc_neg = 1'b0, cc_zero = 1'b0, cc_nan = 1'b0;
    logic eval_go = 1'b0;
    logic [4:0] eval_code = '0;
    logic trap_en = 1'b0, flag_clr = 1'b0;
    logic res_vld, res_bit, unord_flag, trap_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    logic m_n = 0, m_z = 0, m_nan = 0;
    logic m_vld = 0, m_res = 0, m_flag = 0, m_trap = 0;

    always #2 clk = ~clk;

    fpp_cond_unit i_fpp_cond_unit (
        .clk(clk), .rst_n(rst_n), .cc_wr(cc_wr), .cc_neg(cc_neg),
        .cc_zero(cc_zero), .cc_nan(cc_nan), .eval_go(eval_go),
        .eval_code(eval_code), .trap_en(trap_en), .flag_clr(flag_clr),
        .res_vld(res_vld), .res_bit(res_bit), .unord_flag(unord_flag),
        .trap_req(trap_req)
    );

    // accepted classes per relation: bit3 unordered, bit2 greater, bit1 equal, bit0 less
    function automatic logic [3:0] accept_mask(input logic [3:0] rel);
        case (rel)
            4'd0:  return 4'b0000;
            4'd1:  return 4'b0010;
            4'd2:  return 4'b0100;
            4'd3:  return 4'b0110;
            4'd4:  return 4'b0001;
            4'd5:  return 4'b0011;
            4'd6:  return 4'b0101;
            4'd7:  return 4'b0111;
            4'd8:  return 4'b1000;
            4'd9:  return 4'b1010;
            4'd10: return 4'b1100;
            4'd11: return 4'b1110;
            4'd12: return 4'b1001;
            4'd13: return 4'b1011;
            4'd14: return 4'b1101;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int class_of(input logic n, input logic z, input logic u);
        if (u) return 3;
        if (z) return 1;
        if (n) return 0;
        return 2;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_z = 0; m_nan = 0;
            m_vld = 0; m_res = 0; m_flag = 0; m_trap = 0;
        end else begin
            logic [3:0] mk;
            logic ev, hitm;
            mk   = accept_mask(eval_code[3:0]);
            ev   = mk[class_of(m_n, m_z, m_nan)];
            hitm = eval_go && eval_code[4] && m_nan
                   && eval_code[3:0] != 4'd1 && eval_code[3:0] != 4'd14;
            m_vld  = eval_go;
            m_res  = eval_go && ev;
            m_trap = hitm && trap_en;
            if (hitm) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (cc_wr) begin
                m_n = cc_neg; m_z = cc_zero; m_nan = cc_nan;
            end
        end
    end

    // cycle compare against the model
    always @(posedge clk) begin
        #1;
        if (!finished) begin
            chk(res_vld == m_vld, "R6 res_vld", res_vld, m_vld);
            chk(res_bit == m_res, "R2 res_bit", res_bit, m_res);
            chk(unord_flag == m_flag, "R4 unord_flag", unord_flag, m_flag);
            chk(trap_req == m_trap, "R7 trap_req", trap_req, m_trap);
        end
    end

    task automatic set_cc(input logic n, input logic z, input logic u);
        @(negedge clk);
        cc_wr = 1; cc_neg = n; cc_zero = z; cc_nan = u;
        @(negedge clk);
        cc_wr = 0;
    endtask

    task automatic eval_get(input logic [4:0] code, input logic te, output logic r);
        @(negedge clk);
        eval_go = 1; eval_code = code; trap_en = te;
        @(negedge clk);
        eval_go = 0; trap_en = 0;
        r = res_bit;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic r, r2;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!res_vld && !res_bit && !unord_flag && !trap_req, "R9 reset outputs",
            {res_vld, res_bit, unord_flag, trap_req}, 0);
        rst_n = 1;
        @(negedge clk);
        eval_get(5'd2, 0, r);
        chk(r == 1'b1, "R9 reset class greater", r, 1);

        // R2 R4 R7: full sweep over classes and codes
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: set_cc(1, 0, 0);
                1: set_cc(0, 1, 0);
                2: set_cc(0, 0, 0);
                default: set_cc(0, 0, 1);
            endcase
            for (int k = 0; k < 32; k++) begin
                eval_get(5'(k), k[0], r);
                chk(r == accept_mask(4'(k))[c], "R2 sweep", r, accept_mask(4'(k))[c]);
                if (k % 4 == 3) pulse_clr();
            end
        end

        // R3 complement pairs, including unordered
        for (int c = 0; c < 4; c++) begin
            set_cc(c == 0, c == 1, c == 3);
            for (int k = 0; k < 16; k++) begin
                eval_get(5'(k), 0, r);
                eval_get(5'(15 - k), 0, r2);
                chk(r != r2, "R3 complement", r, !r2);
            end
        end
        eval_get(5'd2, 0, r);
        eval_get(5'd5, 0, r2);
        chk(!r && !r2, "R3 unordered gt and le false", {r, r2}, 0);

        // R1 bits held without strobe; capture in same cycle as evaluation
        pulse_clr();
        set_cc(0, 1, 0);
        @(negedge clk);
        cc_neg = 0; cc_zero = 0; cc_nan = 1;
        eval_get(5'd1, 0, r);
        chk(r == 1'b1, "R1 held without strobe", r, 1);
        @(negedge clk);
        cc_wr = 1; cc_nan = 1; eval_go = 1; eval_code = 5'd1;
        @(negedge clk);
        cc_wr = 0; eval_go = 0;
        chk(res_bit == 1'b1, "R1 eval uses old bits", res_bit, 1);
        eval_get(5'd1, 0, r);
        chk(r == 1'b0, "R1 new bits after capture", r, 0);

        // R5 quiet group under unordered never flags
        for (int k = 0; k < 16; k++) eval_get(5'(k), 1, r);
        chk(!unord_flag, "R5 quiet group no flag", unord_flag, 0);
        // R4 exemptions
        eval_get(5'd17, 1, r);
        eval_get(5'd30, 1, r);
        chk(!unord_flag, "R4 equal/not-equal exempt", unord_flag, 0);

        // R8 clear coinciding with set; R7 trap pulse width
        @(negedge clk);
        eval_go = 1; eval_code = 5'd18; trap_en = 1; flag_clr = 1;
        @(negedge clk);
        eval_go = 0; trap_en = 0; flag_clr = 0;
        chk(unord_flag == 1'b1, "R8 set wins over clear", unord_flag, 1);
        chk(trap_req == 1'b1, "R7 trap raised", trap_req, 1);
        @(negedge clk);
        chk(trap_req == 1'b0, "R7 trap single cycle", trap_req, 0);
        chk(unord_flag == 1'b1, "R8 flag sticky", unord_flag, 1);
        pulse_clr();
        chk(unord_flag == 1'b0, "R8 flag cleared", unord_flag, 0);

        // R6 back-to-back evaluations
        @(negedge clk);
        eval_go = 1;
        for (int k = 0; k < 8; k++) begin
            eval_code = 5'(k * 3);
            @(negedge clk);
            chk(res_vld == 1'b1, "R6 back-to-back valid", res_vld, 1);
        end
        eval_go = 0;
        @(negedge clk);
        chk(!res_vld && !res_bit, "R6 idle after burst", {res_vld, res_bit}, 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule